// File: doc/BRIEF.md
# Leading-One Position Encoder

This block scans a 64-bit word from its most significant end and reports where the first set bit sits. It has no clock and no state: the result follows the input through combinational logic only, so it is ready in the same cycle as the input. The position is counted downward from the top. A set bit 63 gives position 0, and a set bit 0 gives position 63.

Two independent paths compute the answer, and they must agree. The first path is a binary tree that halves the word at each of six levels. At each node the half nearer the MSB wins whenever it holds any set bit. The second path reverses the word and keeps only its lowest set bit with the add-and-mask identity `x & (~x + 1)`. It reverses that one-hot word back to the original order and then encodes it. The one-hot word is a port in its own right, because a consumer can use it directly as a grant or select vector. The position output comes from the tree. The one-hot output comes from the arithmetic path. A checker bound to the top module compares the two paths for every input.

Top module: `lod_index_detect`

## Requirements
- R1: `vec_i` is 64 bits wide and `pos_o` is 6 bits wide. The position counts from the MSB: a set bit at port bit b with no set bit above it gives `pos_o` = 63 - b. So bit 63 gives 0 and bit 0 gives 63.
- R2: Only the highest set bit decides the result, and every bit below it has no effect. For example, an input whose top seven bits are clear and whose bit 56 is set gives `pos_o` = 7, whatever the lower 56 bits hold.
- R3: `hit_o` is 1 exactly when `vec_i` holds at least one set bit.
- R4: For an all-zero input, `hit_o` is 0, `pos_o` is 0 and `first_o` is all zeros.
- R5: For a nonzero input, `first_o` has exactly one bit set, at bit 63 - `pos_o`. That bit is also set in `vec_i`, and it is the highest set bit of `vec_i`.
- R6: The block is purely combinational. A new `vec_i` shows up on all outputs within the same cycle, with no clock edge between input and output.
- R7: The position from the halving tree equals the position encoded from the arithmetic one-hot word, for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vec_i | input | 64 | Word to scan |
| pos_o | output | 6 | Position of the first set bit, counted from the MSB |
| hit_o | output | 1 | At least one bit of `vec_i` is set |
| first_o | output | 64 | One-hot word that keeps only the highest set bit of `vec_i` |

## Verification
The hardest cases to reach are the ones where the leading one lies deep in the word and the two paths are most likely to split. These are the tree nodes where a lower half must win after several upper halves came up empty, and the carry in the adder path that runs across a long stretch of zeros. Purely random 64-bit words almost always have a set bit in the top few positions, so they barely touch these cases. The stimulus therefore shifts each random word right by a random amount, which spreads the leading one over all 64 positions. It also walks every single-bit word and a table of hand-picked words with long runs of leading zeros.

// File: rtl/lod_pkg.sv
package lod_pkg;

  // Default scan width of the encoder.
  localparam int unsigned LOD_DEF_W = 64;

  // True when n is a power of two (the tree needs full halving at every level).
  function automatic bit f_is_pow2(input int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/lod_merge.sv
// One node of the halving tree. The MSB-side child wins whenever it holds a set bit.
module lod_merge #(
  parameter int unsigned IW  = 6,
  parameter int unsigned LVL = 1
) (
  input  logic          hi_any,
  input  logic [IW-1:0] hi_pos,
  input  logic          lo_any,
  input  logic [IW-1:0] lo_pos,
  output logic          any,
  output logic [IW-1:0] pos
);
  localparam logic [IW-1:0] LO_BIT = IW'(1) << (LVL - 1);

  assign any = hi_any | lo_any;

  always_comb begin
    if (hi_any)      pos = hi_pos;
    else if (lo_any) pos = lo_pos | LO_BIT;
    else             pos = '0;
  end
endmodule

// File: rtl/lod_tree.sv
// Log-depth halving tree stored as a heap: node 1 is the root and leaves sit at W..2W-1.
// Leaf W+k holds port bit W-1-k, so leaf order runs from the MSB down.
module lod_tree #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] pos
);
  logic          node_any [1:2*W-1];
  logic [IW-1:0] node_pos [1:2*W-1];

  for (genvar k = 0; k < W; k++) begin : g_leaf
    assign node_any[W+k] = vec[W-1-k];
    assign node_pos[W+k] = '0;
  end

  for (genvar h = 1; h <= IW; h++) begin : g_lvl
    localparam int unsigned FIRST = W >> h;
    for (genvar n = FIRST; n < 2*FIRST; n++) begin : g_node
      lod_merge #(.IW(IW), .LVL(h)) u_merge (
        .hi_any (node_any[2*n]),
        .hi_pos (node_pos[2*n]),
        .lo_any (node_any[2*n+1]),
        .lo_pos (node_pos[2*n+1]),
        .any    (node_any[n]),
        .pos    (node_pos[n])
      );
    end
  end

  assign any = node_any[1];
  assign pos = node_pos[1];
endmodule

// File: rtl/lod_isolate.sv
// Arithmetic path: reverse the word, keep its lowest set bit with x & (~x + 1),
// then reverse back so the surviving bit is the MSB-side first one.
module lod_isolate #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] vec,
  output logic         any,
  output logic [W-1:0] onehot
);
  function automatic logic [W-1:0] f_reverse(input logic [W-1:0] x);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = x[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] f_keep_lowest(input logic [W-1:0] x);
    return x & (~x + W'(1));
  endfunction

  logic [W-1:0] rev_vec;
  logic [W-1:0] rev_mask;

  assign rev_vec  = f_reverse(vec);
  assign rev_mask = f_keep_lowest(rev_vec);
  assign onehot   = f_reverse(rev_mask);
  assign any      = |rev_vec;
endmodule

// File: rtl/lod_onehot_enc.sv
// Encodes a one-hot word into a position counted from the MSB: OR tree per output bit.
module lod_onehot_enc #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  onehot,
  output logic [IW-1:0] pos
);
  for (genvar b = 0; b < IW; b++) begin : g_bit
    logic [W-1:0] sel;
    for (genvar k = 0; k < W; k++) begin : g_pos
      localparam logic [IW-1:0] KV = IW'(k);
      if (KV[b]) begin : g_on
        assign sel[k] = onehot[W-1-k];
      end else begin : g_off
        assign sel[k] = 1'b0;
      end
    end
    assign pos[b] = |sel;
  end
endmodule

// File: rtl/lod_index_detect.sv
module lod_index_detect #(
  parameter int unsigned W  = lod_pkg::LOD_DEF_W,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] pos_o,
  output logic          hit_o,
  output logic [W-1:0]  first_o
);
  // Named internal results of both paths, brought out for the checker.
  logic          tree_any;
  logic [IW-1:0] tree_pos;
  logic          iso_any;
  logic [W-1:0]  iso_mask;
  logic [IW-1:0] iso_pos;

  lod_tree #(.W(W), .IW(IW)) u_tree (
    .vec (vec_i),
    .any (tree_any),
    .pos (tree_pos)
  );

  lod_isolate #(.W(W)) u_iso (
    .vec    (vec_i),
    .any    (iso_any),
    .onehot (iso_mask)
  );

  lod_onehot_enc #(.W(W), .IW(IW)) u_enc (
    .onehot (iso_mask),
    .pos    (iso_pos)
  );

  assign pos_o   = tree_pos;
  assign hit_o   = tree_any;
  assign first_o = iso_mask;
endmodule

// File: rtl/lod_index_detect_chk.sv
module lod_index_detect_chk #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = $clog2(W)
) (
  input logic [W-1:0]  vec_i,
  input logic [IW-1:0] pos_o,
  input logic          hit_o,
  input logic [W-1:0]  first_o,
  input logic          tree_any,
  input logic [IW-1:0] tree_pos,
  input logic          iso_any,
  input logic [IW-1:0] iso_pos
);
  always_comb begin
    // R7: both paths give the same position and the same hit flag
    p_paths_agree_r7: assert (tree_pos == iso_pos && tree_any == iso_any)
      else $error("tree pos %0d vs one-hot pos %0d", tree_pos, iso_pos);
    // R3: hit tracks a nonzero input
    p_hit_nonzero_r3: assert (hit_o == (vec_i != '0))
      else $error("hit %b for input %h", hit_o, vec_i);
    // R4: zero input gives zero outputs
    p_zero_clear_r4: assert (vec_i != '0 || (pos_o == '0 && first_o == '0 && !hit_o))
      else $error("zero input gave pos %0d mask %h", pos_o, first_o);
    // R5: mask is at most one-hot and only covers input bits
    p_mask_onehot_r5: assert ($onehot0(first_o) && (first_o & ~vec_i) == '0)
      else $error("bad mask %h for %h", first_o, vec_i);
    // R5: when hit, exactly one bit, located at W-1-pos
    p_mask_at_pos_r5: assert (!hit_o || ($countones(first_o) == 1 && first_o[W-1-pos_o]))
      else $error("mask %h does not match pos %0d", first_o, pos_o);
    // R2: nothing set above the reported bit
    p_none_above_r2: assert (!hit_o || (vec_i >> (W - pos_o)) == '0)
      else $error("set bit above pos %0d in %h", pos_o, vec_i);
  end
endmodule

bind lod_index_detect lod_index_detect_chk #(.W(W), .IW(IW)) u_chk (
  .vec_i    (vec_i),
  .pos_o    (pos_o),
  .hit_o    (hit_o),
  .first_o  (first_o),
  .tree_any (tree_any),
  .tree_pos (tree_pos),
  .iso_any  (iso_any),
  .iso_pos  (iso_pos)
);

// File: tb/test_lod_index_detect.sv
`timescale 1ns/1ps
module test_lod_index_detect;
  localparam int W  = 64;
  localparam int IW = 6;
  localparam int N_TV = 8;
  localparam int N_RAND = 10000;
  localparam int WD_LIMIT = 150000;

  // Stimulus table and expected positions (-1 means no set bit).
  localparam logic [W-1:0] TV_IN [0:N_TV-1] = '{
    64'h0100_0000_0000_0000,
    64'h01D6_A5C3_0F0F_ABCD,
    64'h8000_0000_0000_0001,
    64'h0000_0000_0000_0001,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_0000,
    64'h0000_0001_FFFF_0000,
    64'h0000_0000_8000_0003
  };
  localparam int TV_POS [0:N_TV-1] = '{7, 7, 0, 63, 0, -1, 31, 32};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0]  vec_i = '0;
  logic [IW-1:0] pos_o;
  logic          hit_o;
  logic [W-1:0]  first_o;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lod_index_detect i_lod_index_detect (
    .vec_i   (vec_i),
    .pos_o   (pos_o),
    .hit_o   (hit_o),
    .first_o (first_o)
  );

  // Golden reference: plain scan from the MSB.
  function automatic int ref_scan(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) if (v[W-1-i]) return i;
    return -1;
  endfunction

  task automatic check_now(input string req);
    int exp_pos;
    logic exp_hit;
    logic [IW-1:0] exp_p;
    logic [W-1:0] exp_mask;
    exp_pos  = ref_scan(vec_i);
    exp_hit  = (exp_pos >= 0);
    exp_p    = exp_hit ? IW'(exp_pos) : '0;
    exp_mask = exp_hit ? (W'(1) << (W - 1 - exp_pos)) : '0;
    checks++;
    if (pos_o !== exp_p || hit_o !== exp_hit || first_o !== exp_mask) begin
      errors++;
      $display("FAIL %s in=%h pos=%0d hit=%b mask=%h expected pos=%0d hit=%b mask=%h",
               req, vec_i, pos_o, hit_o, first_o, exp_p, exp_hit, exp_mask);
    end
  endtask

  task automatic apply(input logic [W-1:0] v, input string req);
    @(posedge clk);
    #1 vec_i = v;
    @(negedge clk);
    check_now(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIMIT && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  initial begin
    // R4: state under bench reset, input held at zero
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now("R4 reset zero");
    rst = 1'b0;

    // Table walk (R1, R2, R3, R4)
    for (int t = 0; t < N_TV; t++) begin
      @(posedge clk);
      #1 vec_i = TV_IN[t];
      @(negedge clk);
      checks++;
      if ((TV_POS[t] < 0 && (hit_o !== 1'b0 || pos_o !== '0)) ||
          (TV_POS[t] >= 0 && (hit_o !== 1'b1 || pos_o !== IW'(TV_POS[t])))) begin
        errors++;
        $display("FAIL R1/R2 table %0d in=%h pos=%0d hit=%b expected pos=%0d",
                 t, vec_i, pos_o, hit_o, TV_POS[t]);
      end
      check_now("R2 table vs scan");
    end

    // R1, R5: every single-bit word
    for (int b = 0; b < W; b++) apply(W'(1) << b, "R1 R5 single bit");

    // R2: a fixed leading one with varying lower content has no effect
    for (int j = 0; j < 16; j++)
      apply(64'h0100_0000_0000_0000 | ({$urandom, $urandom} >> 8), "R2 lower bits ignored");

    // R3, R4 corners
    apply('1, "R3 all ones");
    apply('0, "R4 all zero");

    // R6: no clock edge between input change and output
    @(negedge clk);
    vec_i = 64'h0000_0400_0000_0000;
    #0.5 check_now("R6 same-cycle");
    vec_i = 64'h0000_0000_0000_0010;
    #0.5 check_now("R6 same-cycle");

    // R7: random words spread over all positions (paths compared at the ports)
    for (int r = 0; r < N_RAND; r++)
      apply({$urandom, $urandom} >> $urandom_range(63, 0), "R7 random");

    finish_run();
  end
endmodule